// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single read or write requests from an on-chip host into timed cycles on an asynchronous, memory-style external bus, such as a flash card or boot flash port. Each cycle is a fixed sequence of phases: address setup, chip-enable lead, strobe, hold and end pause. Each phase has its own programmable length. A common multiplier scales every phase length, so one set of fields covers a wide range of bus clock rates.

The host presents a command with an address and write data, and it waits while `reqReady` is low. The sequencer latches the command and drives the address, an active-low chip enable, active-low read and write strobes, and the write data. It samples read data as the read strobe is released. A dynamic wait mode lets a slow device hold the strobe low through a ready input. A further programmable count is added after ready. The data path runs at full width, or at half width on the low byte lane.

Top module: `xbus_cycle_seq`

## Requirements
- R1: After a request is accepted, the address is valid first, the chip enable goes low, then the strobe goes low, then the strobe goes high, and then the chip enable goes high. A strobe is never low while the chip enable is high.
- R2: Every phase lasts (field + 1) x multiplier clock cycles, so a field value of 0 with multiplier 1 gives one clock.
- R3: Reads use `tRdStb` and `tRdHold`, and writes use `tWrStb` and `tWrHold`. Only the strobe for the cycle's direction goes low (`busOeN` for reads, `busWeN` for writes). The two strobes are never low together.
- R4: When `cfgWaitMode` is 1, the strobe stays low until the programmed strobe count has elapsed and `busReadyIn` has been sampled high. It then stays low for a further (`tWaitExt` + 1) x multiplier clocks. When `cfgWaitMode` is 0, `busReadyIn` is ignored.
- R5: Read data is taken from `busDataIn` at the clock edge on which `busOeN` returns high. It is the value present while the strobe was still low.
- R6: While `cfgEnable` is 0, requests are ignored: no cycle starts, `busCeN` stays high and `reqReady` stays high.
- R7: `cfgMult` encodes the multiplier as a power of two: 0 gives x1, 1 gives x2, 2 gives x4 and 3 gives x8.
- R8: When `cfgWide` is 1, all 16 data bits are used. When it is 0, only bits 7:0 carry data: written data is driven as `{8'h00, data[7:0]}` and read data is returned with bits 15:8 at zero.
- R9: `reqReady` is high only when no cycle is in progress. It falls in the clock after acceptance and rises when the pause phase completes. Address, data and direction are latched at acceptance, so request inputs that change later have no effect on the cycle.
- R10: Reset, whenever it is applied, forces `busCeN`, `busOeN` and `busWeN` high, `busDataOe` and `doneValid` low, and `reqReady` high.
- R11: For a write, `busDataOe` is high from the first address-phase clock through the last hold-phase clock. For a read, it stays low.
- R12: `doneValid` pulses for exactly one clock, in the first clock after the hold phase, which is the same clock in which `busCeN` rises. `doneRdata` carries the read data, or zero for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Region enable; requests are ignored when low |
| cfgWide | input | 1 | 1: 16-bit data, 0: 8-bit data on the low lane |
| cfgWaitMode | input | 1 | 1: strobe stretched by busReadyIn |
| cfgMult | input | 2 | Multiplier exponent applied to every phase |
| tAdr | input | 6 | Address setup before chip enable, minus one |
| tCe | input | 6 | Chip enable to strobe, minus one |
| tRdStb | input | 6 | Read strobe width, minus one |
| tWrStb | input | 6 | Write strobe width, minus one |
| tRdHold | input | 6 | Read hold after strobe, minus one |
| tWrHold | input | 6 | Write hold after strobe, minus one |
| tPause | input | 6 | End pause, minus one |
| tWaitExt | input | 6 | Strobe extension after ready, minus one |
| reqValid | input | 1 | Host command present |
| reqWrite | input | 1 | 1: write, 0: read |
| reqAddr | input | 16 | Command address |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | Sequencer idle; a command is accepted this clock |
| doneValid | output | 1 | One-clock completion pulse |
| doneRdata | output | 16 | Read data returned with doneValid |
| busAddr | output | 16 | External address |
| busCeN | output | 1 | Chip enable, active low |
| busOeN | output | 1 | Read strobe, active low |
| busWeN | output | 1 | Write strobe, active low |
| busDataOut | output | 16 | Write data to the pad |
| busDataOe | output | 1 | Data pad output enable |
| busDataIn | input | 16 | Read data from the pad |
| busReadyIn | input | 1 | Device ready, used in wait mode |

## Verification
The hardest case to reach from the ports is a strobe held low by a device that is not ready after the programmed strobe count has expired. In that case the counter sits at zero and the post-ready extension must still follow. The bench models the device in step with the bus. It counts the clocks the strobe has been low and raises ready only after a per-vector number of clocks. Some vectors use a late ready, some an early ready and some an always-ready device, so that both terms of the stretched width are exercised. The read data model returns a poison value whenever the read strobe is high, so sampling even one clock late is visible.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADR,
    PH_LEAD,
    PH_STB,
    PH_WEXT,
    PH_HOLD,
    PH_PAUSE
  } phase_e;

  // strobes from control to datapath, computed for the next clock
  typedef struct packed {
    logic ceOn;
    logic oeOn;
    logic weOn;
    logic driveOn;
    logic load;
    logic capture;
    logic done;
  } busCtl_t;

endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int MULT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgWaitMode,
  input  logic [MULT_W-1:0] cfgMult,
  input  logic [CNT_W-1:0]  tAdr,
  input  logic [CNT_W-1:0]  tCe,
  input  logic [CNT_W-1:0]  tRdStb,
  input  logic [CNT_W-1:0]  tWrStb,
  input  logic [CNT_W-1:0]  tRdHold,
  input  logic [CNT_W-1:0]  tWrHold,
  input  logic [CNT_W-1:0]  tPause,
  input  logic [CNT_W-1:0]  tWaitExt,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              busReadyIn,
  output logic              reqReady,
  output busCtl_t           ctl
);

  localparam int LEN_W = CNT_W + (2 ** MULT_W);

  phase_e           phase, phaseNxt;
  logic [LEN_W-1:0] cnt, cntNxt;
  logic             isWrite, isWriteNxt;
  logic             cntZero, accept;

  function automatic logic [LEN_W-1:0] phaseLoad(input logic [CNT_W-1:0] f,
                                                 input logic [MULT_W-1:0] m);
    logic [LEN_W-1:0] base;
    base = LEN_W'(f) + LEN_W'(1);
    return (base << m) - LEN_W'(1);
  endfunction

  assign cntZero  = (cnt == '0);
  assign reqReady = (phase == PH_IDLE);
  assign accept   = reqReady && reqValid && cfgEnable;

  always_comb begin
    phaseNxt   = phase;
    cntNxt     = cntZero ? cnt : cnt - LEN_W'(1);
    isWriteNxt = isWrite;
    unique case (phase)
      PH_IDLE: begin
        cntNxt = cnt;
        if (accept) begin
          phaseNxt   = PH_ADR;
          cntNxt     = phaseLoad(tAdr, cfgMult);
          isWriteNxt = reqWrite;
        end
      end
      PH_ADR: if (cntZero) begin
        phaseNxt = PH_LEAD;
        cntNxt   = phaseLoad(tCe, cfgMult);
      end
      PH_LEAD: if (cntZero) begin
        phaseNxt = PH_STB;
        cntNxt   = phaseLoad(isWrite ? tWrStb : tRdStb, cfgMult);
      end
      PH_STB: if (cntZero) begin
        if (!cfgWaitMode) begin
          phaseNxt = PH_HOLD;
          cntNxt   = phaseLoad(isWrite ? tWrHold : tRdHold, cfgMult);
        end else if (busReadyIn) begin
          phaseNxt = PH_WEXT;
          cntNxt   = phaseLoad(tWaitExt, cfgMult);
        end
      end
      PH_WEXT: if (cntZero) begin
        phaseNxt = PH_HOLD;
        cntNxt   = phaseLoad(isWrite ? tWrHold : tRdHold, cfgMult);
      end
      PH_HOLD: if (cntZero) begin
        phaseNxt = PH_PAUSE;
        cntNxt   = phaseLoad(tPause, cfgMult);
      end
      PH_PAUSE: if (cntZero) phaseNxt = PH_IDLE;
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_comb begin
    ctl.ceOn    = (phaseNxt == PH_LEAD) || (phaseNxt == PH_STB) ||
                  (phaseNxt == PH_WEXT) || (phaseNxt == PH_HOLD);
    ctl.oeOn    = !isWriteNxt && ((phaseNxt == PH_STB) || (phaseNxt == PH_WEXT));
    ctl.weOn    = isWriteNxt && ((phaseNxt == PH_STB) || (phaseNxt == PH_WEXT));
    ctl.driveOn = isWriteNxt && (phaseNxt != PH_IDLE) && (phaseNxt != PH_PAUSE);
    ctl.load    = accept;
    ctl.capture = !isWrite && ((phase == PH_STB) || (phase == PH_WEXT)) &&
                  (phaseNxt == PH_HOLD);
    ctl.done    = (phase == PH_HOLD) && (phaseNxt == PH_PAUSE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else begin
      phase   <= phaseNxt;
      cnt     <= cntNxt;
      isWrite <= isWriteNxt;
    end
  end

endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic              cfgWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busCeN,
  output logic              busOeN,
  output logic              busWeN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRdata
);

  localparam int LANE_W = DATA_W / 2;

  logic              wideQ;
  logic [DATA_W-1:0] rdataQ;

  function automatic logic [DATA_W-1:0] laneMask(input logic [DATA_W-1:0] d,
                                                 input logic wide);
    return wide ? d : {{(DATA_W - LANE_W){1'b0}}, d[LANE_W-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr    <= '0;
      busDataOut <= '0;
      wideQ      <= 1'b1;
      rdataQ     <= '0;
    end else begin
      if (ctl.load) begin
        busAddr    <= reqAddr;
        busDataOut <= laneMask(reqWdata, cfgWide);
        wideQ      <= cfgWide;
        rdataQ     <= '0;
      end
      if (ctl.capture) rdataQ <= laneMask(busDataIn, wideQ);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busCeN    <= 1'b1;
      busOeN    <= 1'b1;
      busWeN    <= 1'b1;
      busDataOe <= 1'b0;
      doneValid <= 1'b0;
    end else begin
      busCeN    <= !ctl.ceOn;
      busOeN    <= !ctl.oeOn;
      busWeN    <= !ctl.weOn;
      busDataOe <= ctl.driveOn;
      doneValid <= ctl.done;
    end
  end

  assign doneRdata = rdataQ;

endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6,
  parameter int MULT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgWide,
  input  logic              cfgWaitMode,
  input  logic [MULT_W-1:0] cfgMult,
  input  logic [CNT_W-1:0]  tAdr,
  input  logic [CNT_W-1:0]  tCe,
  input  logic [CNT_W-1:0]  tRdStb,
  input  logic [CNT_W-1:0]  tWrStb,
  input  logic [CNT_W-1:0]  tRdHold,
  input  logic [CNT_W-1:0]  tWrHold,
  input  logic [CNT_W-1:0]  tPause,
  input  logic [CNT_W-1:0]  tWaitExt,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busCeN,
  output logic              busOeN,
  output logic              busWeN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busReadyIn
);

  busCtl_t ctl;

  xbus_ctrl #(.CNT_W(CNT_W), .MULT_W(MULT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgWaitMode(cfgWaitMode),
    .cfgMult(cfgMult), .tAdr(tAdr), .tCe(tCe), .tRdStb(tRdStb), .tWrStb(tWrStb),
    .tRdHold(tRdHold), .tWrHold(tWrHold), .tPause(tPause), .tWaitExt(tWaitExt),
    .reqValid(reqValid), .reqWrite(reqWrite), .busReadyIn(busReadyIn),
    .reqReady(reqReady), .ctl(ctl)
  );

  xbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgWide(cfgWide), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busDataIn(busDataIn), .busAddr(busAddr),
    .busCeN(busCeN), .busOeN(busOeN), .busWeN(busWeN), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .doneValid(doneValid), .doneRdata(doneRdata)
  );

endmodule

// File: rtl/xbus_cycle_seq_chk.sv
module xbus_cycle_seq_chk (
  input logic clk,
  input logic rstN,
  input logic cfgEnable,
  input logic reqValid,
  input logic reqReady,
  input logic doneValid,
  input logic busCeN,
  input logic busOeN,
  input logic busWeN,
  input logic busDataOe
);

  // R1
  strobe_inside_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busOeN || !busWeN) |-> !busCeN);

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!busOeN && !busWeN));

  // R11
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> busOeN);

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R12
  done_with_ce_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $rose(busCeN));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && cfgEnable) |=> !reqReady);

  // R6
  disabled_stays_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !cfgEnable) |=> (reqReady && busCeN));

endmodule

bind xbus_cycle_seq xbus_cycle_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .reqValid(reqValid),
  .reqReady(reqReady), .doneValid(doneValid), .busCeN(busCeN),
  .busOeN(busOeN), .busWeN(busWeN), .busDataOe(busDataOe)
);

// File: tb/tb_xbus_cycle_seq.sv
`timescale 1ns/1ps
module tb_xbus_cycle_seq;

  typedef struct packed {
    logic        wr;
    logic        wm;
    logic        wide;
    logic [1:0]  mult;
    logic [5:0]  adr, ce, oe, we, rh, wh, ps, wt;
    logic [4:0]  k;
    logic [15:0] addr, data;
  } vec_t;

  // wr wm wide mult | adr ce oe we rh wh ps wt | ready-after | addr data
  localparam vec_t VECS [8] = '{
    '{1'b0,1'b0,1'b1,2'd0, 6'd0,6'd0,6'd0,6'd0,6'd0,6'd0,6'd0,6'd0, 5'd0, 16'h1234,16'h0000},
    '{1'b1,1'b0,1'b1,2'd0, 6'd2,6'd1,6'd7,6'd3,6'd5,6'd2,6'd1,6'd0, 5'd0, 16'h0456,16'hBEEF},
    '{1'b0,1'b0,1'b1,2'd1, 6'd1,6'd0,6'd3,6'd9,6'd2,6'd7,6'd1,6'd0, 5'd0, 16'h2A10,16'h0000},
    '{1'b1,1'b0,1'b0,2'd2, 6'd0,6'd1,6'd4,6'd1,6'd3,6'd0,6'd0,6'd0, 5'd0, 16'h00C3,16'hABCD},
    '{1'b0,1'b1,1'b1,2'd0, 6'd0,6'd0,6'd2,6'd0,6'd1,6'd0,6'd0,6'd2, 5'd9, 16'h3001,16'h0000},
    '{1'b1,1'b1,1'b1,2'd0, 6'd1,6'd0,6'd0,6'd4,6'd0,6'd1,6'd2,6'd0, 5'd1, 16'h0777,16'h1357},
    '{1'b0,1'b0,1'b0,2'd3, 6'd0,6'd0,6'd1,6'd0,6'd0,6'd0,6'd0,6'd0, 5'd0, 16'h5555,16'h0000},
    '{1'b0,1'b1,1'b1,2'd0, 6'd1,6'd1,6'd3,6'd0,6'd0,6'd0,6'd1,6'd1, 5'd0, 16'h6C0F,16'h0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 1'b1, cfgWide = 1'b1, cfgWaitMode = 1'b0;
  logic [1:0] cfgMult = '0;
  logic [5:0] tAdr = '0, tCe = '0, tRdStb = '0, tWrStb = '0;
  logic [5:0] tRdHold = '0, tWrHold = '0, tPause = '0, tWaitExt = '0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic reqReady, doneValid, busCeN, busOeN, busWeN, busDataOe;
  logic [15:0] doneRdata, busAddr, busDataOut, busDataIn;
  logic busReadyIn = 1'b1;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  // device model: poison whenever the read strobe is high
  assign busDataIn = busOeN ? 16'hDEAD : (busAddr ^ 16'h5A3C);

  xbus_cycle_seq dut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgWide(cfgWide),
    .cfgWaitMode(cfgWaitMode), .cfgMult(cfgMult), .tAdr(tAdr), .tCe(tCe),
    .tRdStb(tRdStb), .tWrStb(tWrStb), .tRdHold(tRdHold), .tWrHold(tWrHold),
    .tPause(tPause), .tWaitExt(tWaitExt), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .doneValid(doneValid), .doneRdata(doneRdata), .busAddr(busAddr),
    .busCeN(busCeN), .busOeN(busOeN), .busWeN(busWeN), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .busDataIn(busDataIn), .busReadyIn(busReadyIn)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  task automatic chkIdleOutputs(input string tag);
    chk("R10", {tag, " busCeN"}, int'(busCeN), 1);
    chk("R10", {tag, " busOeN"}, int'(busOeN), 1);
    chk("R10", {tag, " busWeN"}, int'(busWeN), 1);
    chk("R10", {tag, " busDataOe"}, int'(busDataOe), 0);
    chk("R10", {tag, " doneValid"}, int'(doneValid), 0);
    chk("R10", {tag, " reqReady"}, int'(reqReady), 1);
  endtask

  task automatic runVec(input vec_t v, input int idx);
    int m, la, lc, ls, lh, lp, lw, stbLen;
    int ceFall, ceRise, stbFall, stbRise, doneAt, doneCnt, readyAt;
    int drvFirst, drvLast, wrongStb, ceFalls, lowCnt;
    logic prevCe, stbN, othN;
    logic [15:0] addrSeen, dataSeen, rdSeen, expRd, expWr;
    string tag;
    tag = $sformatf("vec%0d", idx);
    m  = 1 << v.mult;                                  // R7
    la = (int'(v.adr) + 1) * m;                        // R2
    lc = (int'(v.ce) + 1) * m;
    ls = (int'(v.wr ? v.we : v.oe) + 1) * m;           // R3
    lh = (int'(v.wr ? v.wh : v.rh) + 1) * m;
    lp = (int'(v.ps) + 1) * m;
    lw = (int'(v.wt) + 1) * m;
    stbLen = v.wm ? (((ls > int'(v.k)) ? ls : int'(v.k)) + lw) : ls;   // R4
    expRd = v.wide ? (v.addr ^ 16'h5A3C) : {8'h00, v.addr[7:0] ^ 8'h3C};
    expWr = v.wide ? v.data : {8'h00, v.data[7:0]};
    ceFall = 0; ceRise = 0; stbFall = 0; stbRise = 0; doneAt = 0; doneCnt = 0;
    readyAt = 0; drvFirst = 0; drvLast = 0; wrongStb = 0; ceFalls = 0; lowCnt = 0;
    prevCe = 1'b1; addrSeen = '0; dataSeen = '0; rdSeen = '0;

    @(negedge clk);
    cfgWide = v.wide; cfgWaitMode = v.wm; cfgMult = v.mult;
    tAdr = v.adr; tCe = v.ce; tRdStb = v.oe; tWrStb = v.we;
    tRdHold = v.rh; tWrHold = v.wh; tPause = v.ps; tWaitExt = v.wt;
    busReadyIn = (v.k == 0);
    reqWrite = v.wr; reqAddr = v.addr; reqWdata = v.data; reqValid = 1'b1;
    @(posedge clk);
    #1;
    // R9: request inputs change and stay valid during the cycle
    reqAddr = ~v.addr; reqWdata = ~v.data; reqWrite = ~v.wr;
    for (int n = 1; n <= 600; n++) begin
      @(negedge clk);
      stbN = v.wr ? busWeN : busOeN;
      othN = v.wr ? busOeN : busWeN;
      if (!busCeN && prevCe) ceFalls++;
      if (!busCeN && ceFall == 0) ceFall = n;
      if (ceFall != 0 && busCeN && ceRise == 0) ceRise = n;
      if (!stbN && stbFall == 0) begin
        stbFall = n; addrSeen = busAddr; dataSeen = busDataOut;
      end
      if (stbFall != 0 && stbN && stbRise == 0) stbRise = n;
      if (!othN) wrongStb++;
      if (busDataOe) begin
        if (drvFirst == 0) drvFirst = n;
        drvLast = n;
      end
      if (doneValid) begin doneCnt++; doneAt = n; rdSeen = doneRdata; end
      prevCe = busCeN;
      if (!stbN) lowCnt++;
      busReadyIn = (lowCnt >= int'(v.k));
      if (reqReady) begin readyAt = n; reqValid = 1'b0; break; end
    end
    chk("R1", {tag, " chip enable falls"}, ceFall, la + 1);
    chk("R2", {tag, " strobe falls"}, stbFall, la + lc + 1);
    chk(v.wm ? "R4" : "R2", {tag, " strobe rises"}, stbRise, la + lc + stbLen + 1);
    chk("R1", {tag, " chip enable rises"}, ceRise, la + lc + stbLen + lh + 1);
    chk("R3", {tag, " other strobe low cycles"}, wrongStb, 0);
    chk("R12", {tag, " done cycle"}, doneAt, la + lc + stbLen + lh + 1);
    chk("R12", {tag, " done pulses"}, doneCnt, 1);
    chk("R9", {tag, " ready returns"}, readyAt, la + lc + stbLen + lh + lp + 1);
    chk("R9", {tag, " single cycle while busy"}, ceFalls, 1);
    chk("R9", {tag, " latched address"}, int'(addrSeen), int'(v.addr));
    if (v.wr) begin
      chk("R8", {tag, " write data on bus"}, int'(dataSeen), int'(expWr));
      chk("R11", {tag, " drive start"}, drvFirst, 1);
      chk("R11", {tag, " drive end"}, drvLast, la + lc + stbLen + lh);
      chk("R12", {tag, " write returns zero"}, int'(rdSeen), 0);
    end else begin
      chk("R11", {tag, " read leaves bus undriven"}, drvFirst, 0);
      chk(v.wide ? "R5" : "R8", {tag, " read data"}, int'(rdSeen), int'(expRd));
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual 150000 cycles expected completion earlier");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R10: state during reset
    repeat (3) @(negedge clk);
    chkIdleOutputs("in reset");
    rstN = 1'b1;
    @(negedge clk);
    chkIdleOutputs("after reset");

    foreach (VECS[i]) runVec(VECS[i], i);

    // R6: disabled region ignores requests
    @(negedge clk);
    cfgEnable = 1'b0; cfgWaitMode = 1'b0; reqWrite = 1'b1; reqValid = 1'b1;
    begin
      int ceLow, rdyLow, dn;
      ceLow = 0; rdyLow = 0; dn = 0;
      for (int n = 0; n < 30; n++) begin
        @(negedge clk);
        if (!busCeN) ceLow++;
        if (!reqReady) rdyLow++;
        if (doneValid) dn++;
      end
      chk("R6", "disabled chip enable low cycles", ceLow, 0);
      chk("R6", "disabled reqReady low cycles", rdyLow, 0);
      chk("R6", "disabled done pulses", dn, 0);
    end
    reqValid = 1'b0; cfgEnable = 1'b1;
    runVec(VECS[1], 8);

    // R10: reset in the middle of a write strobe
    @(negedge clk);
    cfgWide = 1'b1; cfgWaitMode = 1'b0; cfgMult = 2'd1;
    tAdr = 6'd1; tCe = 6'd1; tWrStb = 6'd9; tWrHold = 6'd3; tPause = 6'd1;
    reqWrite = 1'b1; reqAddr = 16'h0F0F; reqWdata = 16'h4242; reqValid = 1'b1;
    @(posedge clk);
    #1 reqValid = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10", "pre-reset write strobe low", int'(busWeN), 0);
    rstN = 1'b0;
    @(negedge clk);
    chkIdleOutputs("mid-cycle reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "idle after reset release", int'(busCeN), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule